// File: doc/BRIEF.md
# Commit-Stage Squash Arbiter

This block sits in the commit stage of an out-of-order core and runs a separate arbiter for each hardware thread. Every cycle it decides which squash source, if any, takes effect for that thread. It then drives the squash broadcast to the earlier pipeline stages. There are two kinds of source. A full-thread squash comes from a delayed trap, from a thread-context request, or from a pending squash-after. An execute-stage squash carries its own sequence number, along with include-self, mispredict, unconditional-branch and taken flags.

Each thread runs a small state machine with four states. Its transitions are:
- RUN to ROBSQ on any squash that is taken.
- RUN to TRAP_PEND on a trap request.
- RUN to SQA_PEND on a squash-after request.
- ROBSQ to ROBSQ on a new squash.
- ROBSQ to RUN when the buffer reports that it is done squashing.
- TRAP_PEND to ROBSQ when the trap flag is taken.
- SQA_PEND to ROBSQ on the very next cycle.

A per-thread trap timer starts when the thread enters TRAP_PEND. It sets the trap flag once the programmed latency has elapsed. The arbiter also keeps the youngest sequence number it tracks for each thread. The buffer loads that number as instructions arrive, and every squash rewrites it.

Top module: `commit_squash_arbiter`

## Requirements
- R1: The full-thread sources are ranked trap flag first, then thread-context request, then squash-after pending. A thread-context request is ignored while the thread is in TRAP_PEND. If a full-thread squash and an execute squash arrive for a thread in the same cycle, the execute squash is dropped.
- R2: An execute squash is accepted only when the thread is not in TRAP_PEND and its reported sequence number is less than or equal to the tracked youngest sequence number. A rejected execute squash produces no pulse.
- R3: When include-self is set, the effective squash point is the reported sequence number minus one. The acceptance compare still uses the reported number.
- R4: An accepted execute squash has four effects in the following cycle. It gives a one-cycle squash pulse with the done sequence number equal to the effective point. It sets the youngest sequence number to that point. It raises the ROB-squashing level. It puts the thread in ROBSQ (status code 1).
- R5: On an accepted execute squash, branch-taken is 1 when both the mispredict and unconditional flags are set. Otherwise it equals the taken input. Branch-taken is 0 for a full-thread squash.
- R6: The ROB-squashing level stays high in every cycle the thread is in ROBSQ. The thread returns to RUN (code 0) after the cycle in which done-squashing is sampled. A new squash in that same cycle wins, and the thread stays in ROBSQ.
- R7: A trap request in RUN puts the thread in TRAP_PEND (code 2) and loads the shared 8-bit latency L. Counting from the edge that samples the request, the trap flag is set at edge L+1 and the full-thread squash pulse appears at edge L+2. Taking the trap clears the flag.
- R8: A full-thread squash uses head sequence minus one as its done sequence number. It uses the last committed sequence number instead when the buffer is empty. In both cases it sets the youngest sequence number to the last committed value.
- R9: A squash-after request in RUN puts the thread in SQA_PEND (code 3) with no pulse. The full-thread squash follows on the next edge.
- R10: After reset every thread is in RUN with the youngest value at 0. All outputs are 0. The done sequence number and branch-taken are 0 in every cycle without a squash pulse.
- R11: When no squash is taken, a youngest-load strobe writes the supplied sequence number into the tracked youngest value. Threads act independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_lat | input | LAT_W | Trap latency in cycles, loaded when a trap starts |
| trap_req | input | NUM_THR | Fault or interrupt raises a trap |
| ctx_req | input | NUM_THR | Thread-context squash request |
| sqa_req | input | NUM_THR | Squash-after request from commit |
| ex_sq | input | NUM_THR | Execute-stage squash valid |
| ex_seq | input | NUM_THR x SEQ_W | Execute squash sequence number |
| ex_incl | input | NUM_THR | Include the squashing instruction itself |
| ex_mispred | input | NUM_THR | Squash caused by a branch mispredict |
| ex_uncond | input | NUM_THR | Mispredicted branch is unconditional |
| ex_taken | input | NUM_THR | Branch direction reported by execute |
| yng_ld | input | NUM_THR | Load strobe for the youngest sequence number |
| yng_seq | input | NUM_THR x SEQ_W | Youngest sequence number to load |
| head_seq | input | NUM_THR x SEQ_W | Sequence number at the buffer head |
| rob_empty | input | NUM_THR | Buffer holds no instruction for the thread |
| last_seq | input | NUM_THR x SEQ_W | Last committed sequence number |
| rob_done | input | NUM_THR | Buffer finished squashing |
| sq_pulse | output | NUM_THR | One-cycle squash broadcast |
| rob_sq | output | NUM_THR | ROB-squashing level |
| done_seq | output | NUM_THR x SEQ_W | Squash point, valid with the pulse |
| br_taken | output | NUM_THR | Branch-taken flag sent with the squash |
| thr_state | output | NUM_THR x 2 | Thread status code |
| yng_out | output | NUM_THR x SEQ_W | Tracked youngest sequence number |

## Verification
The bench targets several boundary cases:
- A squash whose sequence number equals the youngest value must be accepted. One a single step younger must be refused, even when include-self would make its effective point look old enough. An off-by-one compare fails one of these two cases.
- A thread-context request and an execute squash held high all through TRAP_PEND must not produce a pulse before the trap fires. The trap pulse is expected on exactly edge L+2, for a non-zero latency and for zero latency, so a timer that is one cycle off, or a source that leaks through, is caught.
- A done-squashing strobe that arrives together with a new older squash must leave the thread in ROBSQ. Same-cycle collisions between a full-thread squash and an execute squash must report the full-thread squash point.

// File: rtl/cmt_sq_pkg.sv
package cmt_sq_pkg;

    // Thread status codes, visible on thr_state
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ROBSQ = 2'd1,
        ST_TRAP  = 2'd2,
        ST_SQA   = 2'd3
    } sq_state_e;

    // Winning full-thread squash source
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TRAP = 2'd1,
        SRC_CTX  = 2'd2,
        SRC_SQA  = 2'd3
    } full_src_e;

endpackage

// File: rtl/cmt_sq_timer.sv
module cmt_sq_timer #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat,
    input  logic             clear,
    output logic             flag_o
);

    logic [LAT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            if (clear) begin
                flag_o <= 1'b0;
            end
            if (start) begin
                cnt_q  <= lat;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                    flag_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    AST_FLAG_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(busy_q)); // R7
    AST_BUSY_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && flag_o)); // R7

endmodule

// File: rtl/cmt_sq_point.sv
module cmt_sq_point #(
    parameter int SEQ_W = 16
) (
    input  logic [SEQ_W-1:0] head_seq,
    input  logic             rob_empty,
    input  logic [SEQ_W-1:0] last_seq,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    output logic [SEQ_W-1:0] full_pt,
    output logic [SEQ_W-1:0] ex_eff
);

    localparam logic [SEQ_W-1:0] ONE = SEQ_W'(1);

    always_comb begin
        full_pt = rob_empty ? last_seq : (head_seq - ONE);
        ex_eff  = ex_incl ? (ex_seq - ONE) : ex_seq;
    end

endmodule

// File: rtl/cmt_sq_thread.sv
module cmt_sq_thread
    import cmt_sq_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] trap_lat,
    input  logic             trap_req,
    input  logic             ctx_req,
    input  logic             sqa_req,
    input  logic             ex_sq,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    input  logic             ex_mispred,
    input  logic             ex_uncond,
    input  logic             ex_taken,
    input  logic             yng_ld,
    input  logic [SEQ_W-1:0] yng_seq,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic             rob_empty,
    input  logic [SEQ_W-1:0] last_seq,
    input  logic             rob_done,
    output logic             sq_pulse_o,
    output logic             rob_sq_o,
    output logic [SEQ_W-1:0] done_seq_o,
    output logic             br_taken_o,
    output logic [1:0]       state_o,
    output logic [SEQ_W-1:0] yng_o
);

    sq_state_e        state_q, state_d;
    full_src_e        src;
    logic             trap_flag;
    logic             full_take, ex_take, take;
    logic             tmr_start, tmr_clear;
    logic [SEQ_W-1:0] full_pt, ex_eff;

    cmt_sq_point #(.SEQ_W(SEQ_W)) point_i (
        .head_seq (head_seq),
        .rob_empty(rob_empty),
        .last_seq (last_seq),
        .ex_seq   (ex_seq),
        .ex_incl  (ex_incl),
        .full_pt  (full_pt),
        .ex_eff   (ex_eff)
    );

    cmt_sq_timer #(.LAT_W(LAT_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .lat   (trap_lat),
        .clear (tmr_clear),
        .flag_o(trap_flag)
    );

    // Fixed-priority choice among full-thread sources
    always_comb begin
        if (state_q == ST_TRAP && trap_flag) begin
            src = SRC_TRAP;
        end else if (state_q != ST_TRAP && ctx_req) begin
            src = SRC_CTX;
        end else if (state_q == ST_SQA) begin
            src = SRC_SQA;
        end else begin
            src = SRC_NONE;
        end
        full_take = (src != SRC_NONE);
        ex_take   = !full_take && ex_sq && (state_q != ST_TRAP) && (ex_seq <= yng_o);
        take      = full_take || ex_take;
        tmr_start = (state_q == ST_RUN) && !take && trap_req;
        tmr_clear = (src == SRC_TRAP);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (take)          state_d = ST_ROBSQ;
                else if (trap_req) state_d = ST_TRAP;
                else if (sqa_req)  state_d = ST_SQA;
            end
            ST_ROBSQ: begin
                if (take)          state_d = ST_ROBSQ;
                else if (rob_done) state_d = ST_RUN;
            end
            ST_TRAP: begin
                if (take)          state_d = ST_ROBSQ;
            end
            ST_SQA: begin
                state_d = ST_ROBSQ;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_pulse_o <= 1'b0;
            rob_sq_o   <= 1'b0;
            done_seq_o <= '0;
            br_taken_o <= 1'b0;
            yng_o      <= '0;
        end else begin
            sq_pulse_o <= take;
            rob_sq_o   <= (state_d == ST_ROBSQ);
            if (full_take) begin
                done_seq_o <= full_pt;
                br_taken_o <= 1'b0;
                yng_o      <= last_seq;
            end else if (ex_take) begin
                done_seq_o <= ex_eff;
                br_taken_o <= (ex_mispred && ex_uncond) ? 1'b1 : ex_taken;
                yng_o      <= ex_eff;
            end else begin
                done_seq_o <= '0;
                br_taken_o <= 1'b0;
                if (yng_ld) yng_o <= yng_seq;
            end
        end
    end

    assign state_o = state_q;

    AST_TRAP_FLAG_ONLY_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        trap_flag |-> (state_q == ST_TRAP)); // R1
    AST_TRAP_BLOCKS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAP && !trap_flag) |=> !sq_pulse_o); // R2
    AST_PULSE_WITH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        sq_pulse_o |-> rob_sq_o); // R4
    AST_EX_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
        ex_take |=> (yng_o == done_seq_o)); // R4
    AST_LEVEL_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rob_sq_o && !sq_pulse_o) |-> $past(rob_sq_o)); // R6
    AST_SQA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SQA) |=> sq_pulse_o); // R9
    AST_DONE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_pulse_o |-> (done_seq_o == '0 && !br_taken_o)); // R10

endmodule

// File: rtl/commit_squash_arbiter.sv
module commit_squash_arbiter #(
    parameter int NUM_THR = 2,
    parameter int SEQ_W   = 16,
    parameter int LAT_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LAT_W-1:0]              trap_lat,
    input  logic [NUM_THR-1:0]            trap_req,
    input  logic [NUM_THR-1:0]            ctx_req,
    input  logic [NUM_THR-1:0]            sqa_req,
    input  logic [NUM_THR-1:0]            ex_sq,
    input  logic [NUM_THR-1:0][SEQ_W-1:0] ex_seq,
    input  logic [NUM_THR-1:0]            ex_incl,
    input  logic [NUM_THR-1:0]            ex_mispred,
    input  logic [NUM_THR-1:0]            ex_uncond,
    input  logic [NUM_THR-1:0]            ex_taken,
    input  logic [NUM_THR-1:0]            yng_ld,
    input  logic [NUM_THR-1:0][SEQ_W-1:0] yng_seq,
    input  logic [NUM_THR-1:0][SEQ_W-1:0] head_seq,
    input  logic [NUM_THR-1:0]            rob_empty,
    input  logic [NUM_THR-1:0][SEQ_W-1:0] last_seq,
    input  logic [NUM_THR-1:0]            rob_done,
    output logic [NUM_THR-1:0]            sq_pulse,
    output logic [NUM_THR-1:0]            rob_sq,
    output logic [NUM_THR-1:0][SEQ_W-1:0] done_seq,
    output logic [NUM_THR-1:0]            br_taken,
    output logic [NUM_THR-1:0][1:0]       thr_state,
    output logic [NUM_THR-1:0][SEQ_W-1:0] yng_out
);

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        cmt_sq_thread #(.SEQ_W(SEQ_W), .LAT_W(LAT_W)) thr_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .trap_lat  (trap_lat),
            .trap_req  (trap_req[g]),
            .ctx_req   (ctx_req[g]),
            .sqa_req   (sqa_req[g]),
            .ex_sq     (ex_sq[g]),
            .ex_seq    (ex_seq[g]),
            .ex_incl   (ex_incl[g]),
            .ex_mispred(ex_mispred[g]),
            .ex_uncond (ex_uncond[g]),
            .ex_taken  (ex_taken[g]),
            .yng_ld    (yng_ld[g]),
            .yng_seq   (yng_seq[g]),
            .head_seq  (head_seq[g]),
            .rob_empty (rob_empty[g]),
            .last_seq  (last_seq[g]),
            .rob_done  (rob_done[g]),
            .sq_pulse_o(sq_pulse[g]),
            .rob_sq_o  (rob_sq[g]),
            .done_seq_o(done_seq[g]),
            .br_taken_o(br_taken[g]),
            .state_o   (thr_state[g]),
            .yng_o     (yng_out[g])
        );
    end

endmodule

// File: tb/commit_squash_arbiter_tb_top.sv
module commit_squash_arbiter_tb_top;

    localparam int NT = 2;
    localparam int SW = 16;
    localparam int LW = 8;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [LW-1:0]         trap_lat;
    logic [NT-1:0]         trap_req, ctx_req, sqa_req, ex_sq, ex_incl;
    logic [NT-1:0]         ex_mispred, ex_uncond, ex_taken, yng_ld, rob_empty, rob_done;
    logic [NT-1:0][SW-1:0] ex_seq, yng_seq, head_seq, last_seq;
    logic [NT-1:0]         sq_pulse, rob_sq, br_taken;
    logic [NT-1:0][SW-1:0] done_seq, yng_out;
    logic [NT-1:0][1:0]    thr_state;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    commit_squash_arbiter #(.NUM_THR(NT), .SEQ_W(SW), .LAT_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .trap_lat(trap_lat), .trap_req(trap_req),
        .ctx_req(ctx_req), .sqa_req(sqa_req), .ex_sq(ex_sq), .ex_seq(ex_seq),
        .ex_incl(ex_incl), .ex_mispred(ex_mispred), .ex_uncond(ex_uncond),
        .ex_taken(ex_taken), .yng_ld(yng_ld), .yng_seq(yng_seq),
        .head_seq(head_seq), .rob_empty(rob_empty), .last_seq(last_seq),
        .rob_done(rob_done), .sq_pulse(sq_pulse), .rob_sq(rob_sq),
        .done_seq(done_seq), .br_taken(br_taken), .thr_state(thr_state),
        .yng_out(yng_out)
    );

    typedef struct packed {
        logic [15:0] yng;
        logic [15:0] seq;
        logic        incl;
        logic        mis;
        logic        unc;
        logic        tkn;
        logic        acc;
        logic [15:0] done;
        logic        br;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'd100, 16'd50,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd50,  1'b0},
        '{16'd100, 16'd50,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'd49,  1'b0},
        '{16'd100, 16'd100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd100, 1'b0},
        '{16'd100, 16'd101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0,   1'b0},
        '{16'd100, 16'd60,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'd60,  1'b1},
        '{16'd100, 16'd60,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'd60,  1'b1},
        '{16'd100, 16'd60,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'd60,  1'b0},
        '{16'd100, 16'd101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0,   1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic release_sq(input int t);
        rob_done[t] = 1'b1;
        tick();
        rob_done[t] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        trap_lat = '0; trap_req = '0; ctx_req = '0; sqa_req = '0; ex_sq = '0;
        ex_incl = '0; ex_mispred = '0; ex_uncond = '0; ex_taken = '0;
        yng_ld = '0; rob_empty = '0; rob_done = '0;
        ex_seq = '0; yng_seq = '0; head_seq = '0; last_seq = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R10 reset state
        chk("R10 pulse", 32'(sq_pulse), 0);
        chk("R10 level", 32'(rob_sq), 0);
        chk("R10 state", 32'(thr_state), 0);
        chk("R10 done", 32'(done_seq[0]), 0);
        chk("R10 youngest", 32'(yng_out[0]), 0);

        // Table of execute squashes on thread 0 (R2 R3 R4 R5 R11)
        for (int i = 0; i < 8; i++) begin
            yng_ld[0] = 1'b1; yng_seq[0] = VECS[i].yng;
            tick();
            yng_ld[0] = 1'b0;
            chk("R11 youngest load", 32'(yng_out[0]), 32'(VECS[i].yng));
            ex_sq[0] = 1'b1; ex_seq[0] = VECS[i].seq; ex_incl[0] = VECS[i].incl;
            ex_mispred[0] = VECS[i].mis; ex_uncond[0] = VECS[i].unc; ex_taken[0] = VECS[i].tkn;
            tick();
            ex_sq[0] = 1'b0;
            chk("R2 accept", 32'(sq_pulse[0]), 32'(VECS[i].acc));
            chk("R3 done point", 32'(done_seq[0]), 32'(VECS[i].done));
            chk("R5 branch taken", 32'(br_taken[0]), 32'(VECS[i].br));
            chk("R4 state", 32'(thr_state[0]), VECS[i].acc ? 1 : 0);
            chk("R11 other thread", 32'(rob_sq[1]), 0);
            if (VECS[i].acc) begin
                chk("R4 youngest", 32'(yng_out[0]), 32'(VECS[i].done));
                release_sq(0);
                chk("R6 back to run", 32'(thr_state[0]), 0);
                chk("R6 level low", 32'(rob_sq[0]), 0);
            end
        end

        // R6 level held, squash beats done
        yng_ld[0] = 1'b1; yng_seq[0] = 16'd200;
        tick();
        yng_ld[0] = 1'b0;
        ex_sq[0] = 1'b1; ex_seq[0] = 16'd150; ex_incl[0] = 1'b0;
        tick();
        ex_sq[0] = 1'b0;
        chk("R4 pulse", 32'(sq_pulse[0]), 1);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R6 level held", 32'(rob_sq[0]), 1);
            chk("R10 pulse one cycle", 32'(sq_pulse[0]), 0);
            chk("R10 done idle", 32'(done_seq[0]), 0);
        end
        ex_sq[0] = 1'b1; ex_seq[0] = 16'd120; rob_done[0] = 1'b1;
        tick();
        ex_sq[0] = 1'b0; rob_done[0] = 1'b0;
        chk("R6 squash beats done", 32'(thr_state[0]), 1);
        chk("R6 new pulse", 32'(sq_pulse[0]), 1);
        chk("R4 youngest 120", 32'(yng_out[0]), 120);
        release_sq(0);

        // R8 + R1: context squash collides with execute squash
        head_seq[0] = 16'd40; last_seq[0] = 16'd30; rob_empty[0] = 1'b0;
        ctx_req[0] = 1'b1; ex_sq[0] = 1'b1; ex_seq[0] = 16'd10;
        ex_mispred[0] = 1'b1; ex_uncond[0] = 1'b1;
        tick();
        ctx_req[0] = 1'b0; ex_sq[0] = 1'b0; ex_mispred[0] = 1'b0; ex_uncond[0] = 1'b0;
        chk("R1 full wins", 32'(done_seq[0]), 39);
        chk("R8 youngest reset", 32'(yng_out[0]), 30);
        chk("R5 full no branch", 32'(br_taken[0]), 0);
        release_sq(0);
        rob_empty[0] = 1'b1;
        ctx_req[0] = 1'b1;
        tick();
        ctx_req[0] = 1'b0; rob_empty[0] = 1'b0;
        chk("R8 empty point", 32'(done_seq[0]), 30);
        release_sq(0);

        // R9 squash-after
        sqa_req[0] = 1'b1;
        tick();
        sqa_req[0] = 1'b0;
        chk("R9 pending state", 32'(thr_state[0]), 3);
        chk("R9 no pulse yet", 32'(sq_pulse[0]), 0);
        tick();
        chk("R9 pulse", 32'(sq_pulse[0]), 1);
        chk("R9 point", 32'(done_seq[0]), 39);
        release_sq(0);

        // R7 trap with latency 3; R1/R2 other sources blocked meanwhile
        trap_lat = 8'd3; head_seq[0] = 16'd70;
        trap_req[0] = 1'b1;
        tick();
        trap_req[0] = 1'b0;
        chk("R7 trap pending", 32'(thr_state[0]), 2);
        ctx_req[0] = 1'b1; ex_sq[0] = 1'b1; ex_seq[0] = 16'd5;
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk("R1 R2 blocked in trap", 32'(sq_pulse[0]), 0);
        end
        tick();
        ctx_req[0] = 1'b0; ex_sq[0] = 1'b0;
        chk("R7 trap pulse", 32'(sq_pulse[0]), 1);
        chk("R7 trap point", 32'(done_seq[0]), 69);
        release_sq(0);
        tick();
        chk("R7 flag cleared", 32'(sq_pulse[0]), 0);

        // R7 zero latency on thread 1, thread 0 unaffected (R11)
        trap_lat = 8'd0; head_seq[1] = 16'd9; rob_empty[1] = 1'b0;
        trap_req[1] = 1'b1;
        tick();
        trap_req[1] = 1'b0;
        tick();
        chk("R7 zero lat no pulse", 32'(sq_pulse[1]), 0);
        tick();
        chk("R7 zero lat pulse", 32'(sq_pulse[1]), 1);
        chk("R7 zero lat point", 32'(done_seq[1]), 8);
        chk("R11 thread 0 idle", 32'(thr_state[0]), 0);
        release_sq(1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule